// File: doc/BRIEF.md
# Double-Buffered Converter Write Interface

This block is the digital front end of a 16-bit parallel-input digital-to-analog converter, rebuilt as synchronous logic that runs on a fast system clock. A host writes a word over a parallel bus using one active-low write strobe and two active-low stage enables. The first stage is a holding register that takes the bus. The second stage is the output register, which takes the holding register. Because the two stages share one strobe but have separate enables, a host can fill the holding registers of several converters one at a time. It then enables every output stage with a single shared strobe, and all the outputs change together.

All strobe, enable and bus inputs are resynchronized through two flip-flops before use. A write takes effect for as long as the resynchronized strobe stays low, and the last value seen before the strobe rises is the one retained. An active-low clear acts asynchronously on both stages and forces them to the two's-complement code for mid-scale. The block has two outputs: the output register itself, and an offset-binary version of it for the resistor-ladder switch drivers.

Top module: `dual_stage_dac_if`

## Requirements
- R1: While `clear_n` is low, both stages hold 0x0000. `dac_code` reads 0x0000 and `ladder_code` reads 0x8000. The clear acts without waiting for a clock edge.
- R2: Clear has priority. While `clear_n` is low, no combination of strobe, enables or bus changes either output.
- R3: With `strobe_n` low and `in_en_n` low, the holding stage takes `bus`. While `out_en_n` is high, `dac_code` does not change.
- R4: With `strobe_n` low, `out_en_n` low and `in_en_n` high, `dac_code` takes the value held in the holding stage and ignores `bus`. The holding stage keeps the last value it took before the strobe rose.
- R5: Neither stage changes while `strobe_n` is high, whatever the enables do. Neither stage changes while both enables are high, whatever the strobe does.
- R6: With `strobe_n`, `in_en_n` and `out_en_n` all low and `clear_n` high, both stages are transparent and `bus` reaches `dac_code`.
- R7: `ladder_code` equals `dac_code` with bit 15 inverted. Code 0x7FFF (full scale) gives 0xFFFF, 0x0000 (mid-scale) gives 0x8000, and 0x8000 (zero) gives 0x0000.
- R8: An input change that is first sampled at rising clock edge k is visible on `dac_code` after rising edge k+2. That is two synchronizer stages plus one register stage.
- R9: When several instances that share `strobe_n` and `out_en_n` but hold different words are updated together, all their `dac_code` outputs change on the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Asynchronous clear to mid-scale, active low |
| strobe_n | input | 1 | Write strobe, active low |
| in_en_n | input | 1 | Holding stage enable, active low |
| out_en_n | input | 1 | Output stage enable, active low |
| bus | input | 16 | Two's-complement data word |
| dac_code | output | 16 | Output stage contents, two's complement |
| ladder_code | output | 16 | Offset-binary code for the ladder switches |

## Verification
The bench sweeps the transparent path over the code space, including the full-scale, zero, mid-scale and all-ones words. A wrong offset-binary conversion would show at these codes as a ladder code that is off by half the range. To show that the holding stage is isolated, the bench changes the bus after a first-stage load. A design that let the output stage read the bus instead of the holding stage would then show the late bus value. The bench drops the clear in the middle of a clock period while every control is active. A synchronous or low-priority clear would then leave a nonzero code until the next edge, or would let writes through. The bench also counts the cycles between the strobe falling and each of three instances changing. An extra or missing register stage, or a per-instance skew, would move one of those counts.

// File: rtl/dual_stage_dac_if.sv
module dual_stage_dac_if #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             strobe_n,
  input  logic             in_en_n,
  input  logic             out_en_n,
  input  logic [WIDTH-1:0] bus,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] ladder_code
);
  localparam int MSB = WIDTH - 1;

  logic [1:0]       rel_q;
  logic [2:0]       ctl_s1, ctl_s2;
  logic [WIDTH-1:0] bus_s1, bus_s2;
  logic [WIDTH-1:0] hold_q, out_q;
  logic             live, ld_hold, ld_out;
  logic [WIDTH-1:0] hold_next;

  always_ff @(posedge clk or negedge clear_n)
    if (!clear_n) rel_q <= '0;
    else          rel_q <= {rel_q[0], 1'b1};

  assign live = rel_q[1];

  always_ff @(posedge clk or negedge clear_n)
    if (!clear_n) begin
      ctl_s1 <= 3'b111;
      ctl_s2 <= 3'b111;
      bus_s1 <= '0;
      bus_s2 <= '0;
    end else begin
      ctl_s1 <= {strobe_n, in_en_n, out_en_n};
      ctl_s2 <= ctl_s1;
      bus_s1 <= bus;
      bus_s2 <= bus_s1;
    end

  assign ld_hold   = live && !ctl_s2[2] && !ctl_s2[1];
  assign ld_out    = live && !ctl_s2[2] && !ctl_s2[0];
  assign hold_next = ld_hold ? bus_s2 : hold_q;

  always_ff @(posedge clk or negedge clear_n)
    if (!clear_n) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (ld_hold) hold_q <= bus_s2;
      if (ld_out)  out_q  <= hold_next;
    end

  assign dac_code    = out_q;
  assign ladder_code = {~out_q[MSB], out_q[MSB-1:0]};
endmodule

module dual_stage_dac_if_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             clear_n,
  input logic             strobe_n,
  input logic             in_en_n,
  input logic             out_en_n,
  input logic             live,
  input logic [WIDTH-1:0] bus,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] ladder_code
);
  localparam logic [WIDTH-1:0] MID_LADDER = {1'b1, {(WIDTH-1){1'b0}}};

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    !clear_n |-> (dac_code == '0 && ladder_code == MID_LADDER));

  // R5
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!clear_n)
    strobe_n |-> ##3 $stable(dac_code));

  // R5
  no_enable_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (in_en_n && out_en_n) |-> ##3 $stable(dac_code));

  // R3
  out_closed_chk: assert property (@(posedge clk) disable iff (!clear_n)
    out_en_n |-> ##3 $stable(dac_code));

  // R6
  transparent_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (live && !strobe_n && !in_en_n && !out_en_n) |-> ##3 (dac_code == $past(bus, 3)));
endmodule

bind dual_stage_dac_if dual_stage_dac_if_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clear_n(clear_n), .strobe_n(strobe_n), .in_en_n(in_en_n),
  .out_en_n(out_en_n), .live(live), .bus(bus), .dac_code(dac_code),
  .ladder_code(ladder_code)
);

// File: tb/tb_dual_stage_dac_if.sv
`timescale 1ns/1ps
module tb_dual_stage_dac_if;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        clear_n = 1'b0, strobe_n = 1'b1, out_en_n = 1'b1;
  logic        en0_n = 1'b1, en1_n = 1'b1, en2_n = 1'b1;
  logic [15:0] bus = '0;
  logic [15:0] dac0, dac1, dac2, lad0, lad1, lad2;
  int checks = 0, fails = 0;
  bit done = 0;

  dual_stage_dac_if dut (.clk(clk), .clear_n(clear_n), .strobe_n(strobe_n), .in_en_n(en0_n),
    .out_en_n(out_en_n), .bus(bus), .dac_code(dac0), .ladder_code(lad0));
  dual_stage_dac_if u_peer1 (.clk(clk), .clear_n(clear_n), .strobe_n(strobe_n), .in_en_n(en1_n),
    .out_en_n(out_en_n), .bus(bus), .dac_code(dac1), .ladder_code(lad1));
  dual_stage_dac_if u_peer2 (.clk(clk), .clear_n(clear_n), .strobe_n(strobe_n), .in_en_n(en2_n),
    .out_en_n(out_en_n), .bus(bus), .dac_code(dac2), .ladder_code(lad2));

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] offbin(logic [15:0] v);
    return 16'((32'(v) + 32768) % 65536);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2;
    logic [15:0] v;
    step(3);
    chk("R1 reset dac", dac0, 16'h0000);
    chk("R1 reset ladder", lad0, 16'h8000);
    chk("R1 reset peer", dac2, 16'h0000);
    clear_n = 1'b1;
    step(4);

    // R3: first stage only, output closed
    bus = 16'h1234; en0_n = 1'b0; strobe_n = 1'b0; step(5);
    strobe_n = 1'b1; step(4);
    en0_n = 1'b1;
    chk("R3 output held", dac0, 16'h0000);
    bus = 16'hFFFF; step(4);

    // R4: second stage takes holding value, bus ignored
    out_en_n = 1'b0; strobe_n = 1'b0; step(5);
    strobe_n = 1'b1; step(4);
    chk("R4 copy from holding", dac0, 16'h1234);

    // R5: strobe high, enables low
    en0_n = 1'b0; bus = 16'h5555; step(6);
    chk("R5 strobe high", dac0, 16'h1234);
    en0_n = 1'b1; out_en_n = 1'b1; strobe_n = 1'b0; step(6);
    chk("R5 enables high", dac0, 16'h1234);
    strobe_n = 1'b1; step(4);

    // R8 latency under transparency
    en0_n = 1'b0; out_en_n = 1'b0; bus = 16'hABCD; step(4);
    strobe_n = 1'b0;
    step(2);
    chk("R8 not before third edge", dac0, 16'h1234);
    step(1);
    chk("R8 at third edge", dac0, 16'hABCD);

    // R6 / R7 sweep
    for (int i = 0; i < 72; i++) begin
      case (i)
        0: v = 16'h7FFF;
        1: v = 16'h8000;
        2: v = 16'h0000;
        3: v = 16'hFFFF;
        default: v = 16'(i * 2749 + 17);
      endcase
      bus = v; step(4);
      chk("R6 transparent", dac0, v);
      chk("R7 offset binary", lad0, offbin(v));
    end

    // R1 / R2: asynchronous clear with everything active
    bus = 16'h7777; step(4);
    #3 clear_n = 1'b0;
    #1 chk("R1 async clear", dac0, 16'h0000);
    chk("R1 async ladder", lad0, 16'h8000);
    step(5);
    chk("R2 clear priority", dac0, 16'h0000);
    clear_n = 1'b1; step(8);
    chk("R6 after clear", dac0, 16'h7777);

    // R9: load three holding stages, then update together
    strobe_n = 1'b1; out_en_n = 1'b1; en0_n = 1'b1; step(4);
    chk("R9 peer1 before", dac1, 16'h0000);
    bus = 16'h1111; en0_n = 1'b0; strobe_n = 1'b0; step(5); strobe_n = 1'b1; step(4); en0_n = 1'b1;
    bus = 16'h2222; en1_n = 1'b0; strobe_n = 1'b0; step(5); strobe_n = 1'b1; step(4); en1_n = 1'b1;
    bus = 16'h3333; en2_n = 1'b0; strobe_n = 1'b0; step(5); strobe_n = 1'b1; step(4); en2_n = 1'b1;
    chk("R3 dut held during loads", dac0, 16'h7777);
    chk("R3 peer2 held during loads", dac2, 16'h0000);
    bus = 16'h9999;
    t0 = -1; t1 = -1; t2 = -1;
    out_en_n = 1'b0; strobe_n = 1'b0;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if (t0 < 0 && dac0 != 16'h7777) t0 = c;
      if (t1 < 0 && dac1 != 16'h0000) t1 = c;
      if (t2 < 0 && dac2 != 16'h0000) t2 = c;
    end
    strobe_n = 1'b1;
    chk("R9 dut value", dac0, 16'h1111);
    chk("R9 peer1 value", dac1, 16'h2222);
    chk("R9 peer2 value", dac2, 16'h3333);
    chk("R9 peer1 same cycle", 16'(t1), 16'(t0));
    chk("R9 peer2 same cycle", 16'(t2), 16'(t0));
    chk("R8 update cycle", 16'(t0), 16'd3);
    step(4);
    finish_run();
  end
endmodule